// File: doc/BRIEF.md
# Two-Parallel Fast FIR Filter

This block is a two-tap FIR filter that consumes two new samples per clock and emits two filtered results per clock. For a stream x, the two taps give y[n] = h0·x[n-1] + h1·x[n]. Each accepted pair (`in_a` older, `in_b` newer) is combined with the newer sample of the previous accepted pair (the history sample) to form two outputs.

The block does not use four products. It forms two input pre-sums, the old sample plus `in_a` and `in_a` plus `in_b`, and multiplies them by h0 and h1. A third product multiplies `in_a` by the tap difference h1 − h0. That difference is computed once, when the taps are loaded, and held in a register. Two post-adds then combine the three products into the results. This costs three multipliers and five adders in all.

Taps are written through a simple load strobe. Results carry full precision with no rounding or saturation. The pipeline has two register stages and accepts a new pair on every cycle.

Top module: `fir2p_fast`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `out_valid` low and both results zero. The history sample is cleared to zero, so the first pair after reset is filtered as if the previous sample were 0.
- R2: For an accepted pair with history sample p, `out_y0` equals h0·p + h1·`in_a` as a signed value.
- R3: For the same pair, `out_y1` equals h0·`in_a` + h1·`in_b` as a signed value.
- R4: A pair sampled with `in_valid` high at edge k is reported with `out_valid` high in the cycle after edge k+1. This is a latency of two cycles. `out_valid` is low in every cycle that has no such pair.
- R5: `in_b` of each accepted pair becomes the history sample for the next accepted pair. Cycles with `in_valid` low leave the history unchanged, however many of them pass.
- R6: A rising edge with `cfg_load` high stores `cfg_h0` and `cfg_h1` together with their difference. Pairs accepted at that edge or later use the new taps. Pairs accepted earlier use the old taps.
- R7: Results keep full precision. With all samples and taps at the most negative or most positive input codes, the reported values equal the exact integer results, with no wraparound.
- R8: Pairs presented on consecutive cycles are all accepted and reported on consecutive cycles, in order.
- R9: While `out_valid` is low, `out_y0` and `out_y1` hold the values of the last reported pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Tap write strobe |
| cfg_h0 | input | 16 | Tap applied to the older sample, signed |
| cfg_h1 | input | 16 | Tap applied to the newer sample, signed |
| in_valid | input | 1 | Input pair valid |
| in_a | input | 16 | Older sample of the pair, signed |
| in_b | input | 16 | Newer sample of the pair, signed |
| out_valid | output | 1 | Result pair valid |
| out_y0 | output | 34 | First result, signed |
| out_y1 | output | 34 | Second result, signed |

## Verification
On every cycle, the assertions check the valid flag moving through both stages, the history sample holding through idle cycles, and the stored tap difference tracking each load. They also check that the tap registers stay stable without a load and that the results hold between reported pairs. Only the bench's scenarios can show that the arithmetic is correct, meaning the fast three-product form matches the direct filter. The same applies to the first pair after reset using a zero history, to a tap load that lands on the same edge as a pair, and to exact results at the extreme codes.

// File: rtl/fir2p_pkg.sv
package fir2p_pkg;

    // Input sample and tap widths.
    localparam int DW  = 16;
    localparam int CW  = 16;
    // Derived widths: pre-sum, tap difference, full-precision result.
    localparam int SW  = DW + 1;
    localparam int DFW = CW + 1;
    localparam int YW  = DW + CW + 2;

    typedef logic signed [DW-1:0]  samp_t;
    typedef logic signed [CW-1:0]  coef_t;
    typedef logic signed [SW-1:0]  psum_t;
    typedef logic signed [DFW-1:0] cdiff_t;
    typedef logic signed [YW-1:0]  acc_t;

    // Stage-one payload: two pre-sums and the shared middle sample.
    typedef struct packed {
        psum_t sum_lo;
        psum_t sum_hi;
        samp_t mid;
    } preadd_t;

    // Tap set with the precomputed difference.
    typedef struct packed {
        coef_t  h0;
        coef_t  h1;
        cdiff_t hd;
    } tapset_t;

    // Result pair.
    typedef struct packed {
        acc_t y0;
        acc_t y1;
    } ypair_t;

    function automatic cdiff_t tap_diff(input coef_t h0, input coef_t h1);
        return cdiff_t'(h1) - cdiff_t'(h0);
    endfunction

    function automatic psum_t pre_add(input samp_t a, input samp_t b);
        return psum_t'(a) + psum_t'(b);
    endfunction

endpackage

// File: rtl/fir2p_tap_bank.sv
module fir2p_tap_bank
    import fir2p_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cfg_load,
    input  coef_t   cfg_h0,
    input  coef_t   cfg_h1,
    output tapset_t taps
);

    tapset_t taps_q;

    // The difference is formed here once per load, not on every sample.
    always_ff @(posedge clk) begin
        if (rst) begin
            taps_q <= '0;
        end else if (cfg_load) begin
            taps_q.h0 <= cfg_h0;
            taps_q.h1 <= cfg_h1;
            taps_q.hd <= tap_diff(cfg_h0, cfg_h1);
        end
    end

    assign taps = taps_q;

    AST_DIFF_FRESH: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> (taps_q.hd == tap_diff($past(cfg_h0), $past(cfg_h1)))); // R6

    AST_TAPS_HELD: assert property (@(posedge clk) disable iff (rst)
        !cfg_load |=> $stable(taps_q)); // R6

endmodule

// File: rtl/fir2p_preadd.sv
module fir2p_preadd
    import fir2p_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  samp_t   in_a,
    input  samp_t   in_b,
    output preadd_t s1_data,
    output logic    s1_valid
);

    samp_t   hist_q;
    preadd_t s1_q;
    logic    v1_q;
    preadd_t s1_d;

    // Two of the five adders: the input pre-sums.
    always_comb begin
        s1_d.sum_lo = pre_add(hist_q, in_a);
        s1_d.sum_hi = pre_add(in_a, in_b);
        s1_d.mid    = in_a;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            s1_q   <= '0;
            v1_q   <= 1'b0;
        end else begin
            v1_q <= in_valid;
            if (in_valid) begin
                hist_q <= in_b;
                s1_q   <= s1_d;
            end
        end
    end

    assign s1_data  = s1_q;
    assign s1_valid = v1_q;

    AST_HIST_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(hist_q)); // R5

    AST_HIST_TAKE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (hist_q == $past(in_b))); // R5

    AST_STAGE1_VALID: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> v1_q); // R4

endmodule

// File: rtl/fir2p_mac.sv
module fir2p_mac
    import fir2p_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  preadd_t s1_data,
    input  logic    s1_valid,
    input  tapset_t taps,
    output ypair_t  res,
    output logic    res_valid
);

    acc_t   p_lo;
    acc_t   p_hi;
    acc_t   p_mid;
    ypair_t res_d;
    ypair_t res_q;
    logic   v2_q;

    // The three shared products.
    always_comb begin
        p_lo  = acc_t'(taps.h0) * acc_t'(s1_data.sum_lo);
        p_hi  = acc_t'(taps.h1) * acc_t'(s1_data.sum_hi);
        p_mid = acc_t'(taps.hd) * acc_t'(s1_data.mid);
        // Post-adds: two of the five adders.
        res_d.y0 = p_lo + p_mid;
        res_d.y1 = p_hi - p_mid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            v2_q  <= 1'b0;
        end else begin
            v2_q <= s1_valid;
            if (s1_valid) begin
                res_q <= res_d;
            end
        end
    end

    assign res       = res_q;
    assign res_valid = v2_q;

    AST_STAGE2_VALID: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> v2_q); // R4

    AST_STAGE2_IDLE: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> !v2_q); // R4

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> $stable(res_q)); // R9

endmodule

// File: rtl/fir2p_fast.sv
module fir2p_fast
    import fir2p_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_load,
    input  logic signed [CW-1:0] cfg_h0,
    input  logic signed [CW-1:0] cfg_h1,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_a,
    input  logic signed [DW-1:0] in_b,
    output logic                 out_valid,
    output logic signed [YW-1:0] out_y0,
    output logic signed [YW-1:0] out_y1
);

    tapset_t taps;
    preadd_t s1_data;
    logic    s1_valid;
    ypair_t  res;
    logic    res_valid;

    fir2p_tap_bank u_taps (
        .clk      (clk),
        .rst      (rst),
        .cfg_load (cfg_load),
        .cfg_h0   (cfg_h0),
        .cfg_h1   (cfg_h1),
        .taps     (taps)
    );

    fir2p_preadd u_pre (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_a     (in_a),
        .in_b     (in_b),
        .s1_data  (s1_data),
        .s1_valid (s1_valid)
    );

    fir2p_mac u_mac (
        .clk       (clk),
        .rst       (rst),
        .s1_data   (s1_data),
        .s1_valid  (s1_valid),
        .taps      (taps),
        .res       (res),
        .res_valid (res_valid)
    );

    assign out_valid = res_valid;
    assign out_y0    = res.y0;
    assign out_y1    = res.y1;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!out_valid && out_y0 == '0 && out_y1 == '0)); // R1

endmodule

// File: tb/fir2p_fast_bench.sv
module fir2p_fast_bench;
    import fir2p_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_load = 1'b0;
    logic signed [CW-1:0] cfg_h0 = '0;
    logic signed [CW-1:0] cfg_h1 = '0;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] in_a = '0;
    logic signed [DW-1:0] in_b = '0;
    logic out_valid;
    logic signed [YW-1:0] out_y0;
    logic signed [YW-1:0] out_y1;

    always #2.5 clk = ~clk;   // 200 MHz

    fir2p_fast u_fir2p_fast (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_h0(cfg_h0), .cfg_h1(cfg_h1),
        .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_y0(out_y0), .out_y1(out_y1)
    );

    typedef struct {
        longint y0;
        longint y1;
        int     cyc;
    } exp_t;

    exp_t   sb[$];
    int     total = 0;
    int     bad = 0;
    int     cyc = 0;
    longint m_h0 = 0, m_h1 = 0, m_prev = 0;
    longint last_y0 = 0, last_y1 = 0;
    bit     done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Driver: called at a falling edge; sets one cycle of stimulus.
    task automatic step(input bit v, input longint a, input longint b,
                        input bit ld, input longint h0, input longint h1);
        exp_t e;
        cfg_load = ld;
        cfg_h0   = CW'(h0);
        cfg_h1   = CW'(h1);
        in_valid = v;
        in_a     = DW'(a);
        in_b     = DW'(b);
        if (ld) begin
            m_h0 = h0;
            m_h1 = h1;
        end
        if (v) begin
            e.y0  = m_h0 * m_prev + m_h1 * a;
            e.y1  = m_h0 * a + m_h1 * b;
            e.cyc = cyc + 2;
            sb.push_back(e);
            m_prev = b;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
    endtask

    // Monitor: compares results with the scoreboard away from the clock edge.
    always @(negedge clk) begin
        if (rst) begin
            last_y0 = 0;
            last_y1 = 0;
        end else if (out_valid) begin
            if (sb.size() == 0) begin
                check(0, "R4 unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(longint'(out_y0) == e.y0, "R2 y0", longint'(out_y0), e.y0);
                check(longint'(out_y1) == e.y1, "R3 y1", longint'(out_y1), e.y1);
                check(cyc == e.cyc, "R4 latency", cyc, e.cyc);
            end
            last_y0 = longint'(out_y0);
            last_y1 = longint'(out_y1);
        end else if (!done) begin
            check(longint'(out_y0) == last_y0 && longint'(out_y1) == last_y1,
                  "R9 hold", longint'(out_y0), last_y0);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", longint'(out_valid), 0);
        check(out_y0 == '0 && out_y1 == '0, "R1 results in reset", longint'(out_y0), 0);
        rst = 1'b0;
        @(negedge clk);

        // Load taps, then a pair in the next cycle; history starts at zero (R1).
        step(0, 0, 0, 1, 3, -5);
        step(1, 7, -2, 0, 0, 0);
        // Back-to-back pairs (R8), history carried forward (R5).
        step(1, 11, 4, 0, 0, 0);
        step(1, -9, 100, 0, 0, 0);
        step(1, 250, -250, 0, 0, 0);
        // Idle gap, history must survive (R5).
        idle(4);
        step(1, 13, 17, 0, 0, 0);
        idle(3);

        // Tap load on the same edge as a pair: the pair uses the new taps (R6).
        step(1, 21, -8, 1, -7, 12);
        // A pair one edge before a load uses the old taps (R6).
        step(1, 5, 6, 0, 0, 0);
        step(0, 0, 0, 1, 40, 41);
        step(1, -3, 9, 0, 0, 0);
        idle(3);

        // Full-precision extremes (R7).
        step(0, 0, 0, 1, -32768, -32768);
        step(1, -32768, -32768, 0, 0, 0);
        step(1, -32768, -32768, 0, 0, 0);
        step(0, 0, 0, 1, 32767, -32768);
        step(1, -32768, 32767, 0, 0, 0);
        step(1, 32767, -32768, 0, 0, 0);
        idle(3);

        // Mixed stream with gaps (R2, R3, R5, R8).
        step(0, 0, 0, 1, -1234, 987);
        for (int i = 0; i < 48; i++) begin
            longint a = ((i * 7919 + 13) % 65536) - 32768;
            longint b = ((i * 104729 + 5) % 65536) - 32768;
            step((i % 5) != 3, a, b, 0, 0, 0);
        end
        idle(3);
        check(sb.size() == 0, "R8 all pairs reported", sb.size(), 0);

        // A second reset clears the history (R1).
        step(1, 100, 200, 0, 0, 0);
        idle(3);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_prev = 0;
        m_h0 = 0;
        m_h1 = 0;
        step(0, 0, 0, 1, 2, 3);
        step(1, 10, 20, 0, 0, 0);
        idle(3);
        check(sb.size() == 0, "R1 queue drained after reset", sb.size(), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule